// File: doc/BRIEF.md
# Single-Lane Flash Command Sequencer

This block runs one short serial-flash command at a time. Software first loads a 32-bit address word and up to eight bytes of outgoing data, then writes a control word. The control word holds the opcode, three optional phases, each with its own byte count, and a dummy-cycle count. If the write also sets the start bit, the command begins. The block drives a single data line, `sdo`, and holds the active-low select, `cs_n`, low for the whole command. It samples `sdi` during the read phase. When the command ends, the received bytes appear in two read-back words.

An external timing block sets the serial bit rate. It pulses `bit_stb` once for each bit period. On each pulse the engine counts the current bit as transferred and moves to the next one. Without a pulse, every output holds its value. This keeps the engine independent of clock division and of the select set-up and hold delays.

The register port is a simple single-cycle write strobe. The read data is combinational and follows the read address.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, `cs_n` is 1 and every register listed in R2 reads zero.
- R2: The register offsets are: control 0x90, address 0x94, read-back low 0xA0, read-back high 0xA4, outgoing data low 0xA8, outgoing data high 0xAC. In the control word, bits [31:24] hold the opcode. Bit 23 enables the read phase and bits [22:20] hold its byte count minus one. Bit 19 enables the address phase and bits [17:16] hold its byte count minus one. Bit 15 enables the write phase and bits [14:12] hold its byte count minus one. Bits [11:7] hold the dummy-cycle count. Control reads return these fields, with bit 1 as the in-progress flag and all other bits 0. The address and outgoing data registers read back as written. Any other offset reads 0.
- R3: A write to 0x90 with bit 0 set, made while idle, starts a command. In the next cycle `cs_n` is 0 and control bit 1 reads 1.
- R4: Each cycle with `bit_stb` high during a command completes one bit. In any other cycle, `sdo`, the bit position and `cs_n` hold their values.
- R5: The phases run in a fixed order: opcode, address, dummy, write, read. Disabled phases are skipped. The 8 opcode bits are sent first, most significant bit first.
- R6: With address enabled and count field n, the low 8·(n+1) bits of the address register are sent, most significant bit first.
- R7: The dummy phase lasts as many bit periods as bits [11:7] give, with `sdo` at 0. A value of 0 skips the phase.
- R8: With write enabled and count field m, m+1 bytes are sent, each most significant bit first. Byte k (0 to 3) is taken from bits [8k+7:8k] of 0xA8. Byte k (4 to 7) is taken from bits [8(k-4)+7:8(k-4)] of 0xAC.
- R9: With read enabled and count field m, m+1 bytes are received. `sdi` is sampled on each strobe, and `sdo` is 0 during the phase. Received byte k is placed at the same position as in R8, but in 0xA0 and 0xA4. Positions not received read 0. The read-back words update in the same cycle the in-progress flag clears. A command without a read phase leaves them unchanged.
- R10: One cycle after the strobe of the last bit, `cs_n` returns to 1 and control bit 1 reads 0. `cs_n` stays 0 for the whole command.
- R11: All register writes made while a command runs are ignored, including a new start request.
- R12: Writes to 0xA0 and 0xA4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| bit_stb | input | 1 | One pulse per serial bit period, from the timing block |
| sdi | input | 1 | Serial data from the flash |
| sdo | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low flash select |

## Verification
The assertions check these properties on every cycle:
- a start enters the opcode phase at bit zero;
- the bit position and phase stay frozen between strobes;
- the bit position stays within the current phase length;
- the phase only moves forward until idle;
- a completed command returns to idle;
- writes made while busy leave the configuration unchanged;
- writes to the read-back offsets leave those words unchanged.

Only the bench's scenarios can show the rest. That covers the exact serial bit order for each phase mix and the byte placement within the two data words. It also covers clearing of unreceived read positions and read-back values after commands that were requested during a busy period and then ignored. The bench compares these against a bit-queue model on every clock.

// File: rtl/fce_pkg.sv
`timescale 1ns/1ps
package fce_pkg;
  localparam int REG_AW = 8;
  localparam int WORD_W = 32;
  localparam int NWORDS = 2;
  localparam int DATA_W = WORD_W * NWORDS;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int CNT_W  = POS_W + 1;
  localparam int OPC_W  = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h90;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 8'h94;
  localparam logic [REG_AW-1:0] OFS_RD_LO = 8'hA0;
  localparam logic [REG_AW-1:0] OFS_WR_LO = 8'hA8;
  localparam int BIT_GO   = 0;
  localparam int BIT_BUSY = 1;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_WR    = 3'd4,
    PH_RD    = 3'd5
  } phase_e;

  // phase shape of one command (opcode kept apart)
  typedef struct packed {
    logic       rd_en;
    logic [2:0] rd_cnt;
    logic       addr_en;
    logic [1:0] addr_cnt;
    logic       wr_en;
    logic [2:0] wr_cnt;
    logic [4:0] dummy;
  } cmd_t;

  function automatic cmd_t cmd_unpack(logic [WORD_W-1:0] w);
    cmd_t c;
    c.rd_en    = w[23];
    c.rd_cnt   = w[22:20];
    c.addr_en  = w[19];
    c.addr_cnt = w[17:16];
    c.wr_en    = w[15];
    c.wr_cnt   = w[14:12];
    c.dummy    = w[11:7];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cmd_pack(cmd_t c, logic [OPC_W-1:0] op, logic busy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[31:24] = op;
    w[23]    = c.rd_en;
    w[22:20] = c.rd_cnt;
    w[19]    = c.addr_en;
    w[17:16] = c.addr_cnt;
    w[15]    = c.wr_en;
    w[14:12] = c.wr_cnt;
    w[11:7]  = c.dummy;
    w[BIT_BUSY] = busy;
    return w;
  endfunction

  function automatic logic phase_on(phase_e p, cmd_t c);
    case (p)
      PH_OPC:   return 1'b1;
      PH_ADDR:  return c.addr_en;
      PH_DUMMY: return (c.dummy != 5'd0);
      PH_WR:    return c.wr_en;
      PH_RD:    return c.rd_en;
      default:  return 1'b0;
    endcase
  endfunction

  // bytes (count field + 1) expressed in bits
  function automatic logic [CNT_W-1:0] bytes_to_bits(logic [2:0] cnt_m1);
    logic [CNT_W-1:0] n;
    n = {{(CNT_W-3){1'b0}}, cnt_m1} + CNT_W'(1);
    return n << 3;
  endfunction

  function automatic logic [CNT_W-1:0] phase_len(phase_e p, cmd_t c);
    case (p)
      PH_OPC:   return CNT_W'(OPC_W);
      PH_ADDR:  return bytes_to_bits({1'b0, c.addr_cnt});
      PH_DUMMY: return {{(CNT_W-5){1'b0}}, c.dummy};
      PH_WR:    return bytes_to_bits(c.wr_cnt);
      PH_RD:    return bytes_to_bits(c.rd_cnt);
      default:  return CNT_W'(1);
    endcase
  endfunction

  // first enabled phase strictly after p, or idle
  function automatic phase_e phase_after(phase_e p, cmd_t c);
    phase_e r;
    r = PH_IDLE;
    for (int k = int'(PH_RD); k > int'(p); k--) begin
      if (phase_on(phase_e'(k[2:0]), c)) r = phase_e'(k[2:0]);
    end
    return r;
  endfunction

  // address bit sent at position i of an address phase of n+1 bytes
  function automatic logic [4:0] addr_pos(logic [1:0] n, logic [CNT_W-1:0] i);
    logic [CNT_W-1:0] t;
    t = bytes_to_bits({1'b0, n}) - CNT_W'(1) - i;
    return t[4:0];
  endfunction

  // data bit position for serial index i: byte i/8, msb first
  function automatic logic [POS_W-1:0] data_pos(logic [CNT_W-1:0] i);
    return {i[POS_W-1:3], ~i[2:0]};
  endfunction
endpackage

// File: rtl/fce_regs.sv
`timescale 1ns/1ps
module fce_regs
  import fce_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 busy,
  input  logic                 finish,
  input  logic [DATA_W-1:0]    rd_capture,
  output cmd_t                 cfg,
  output logic [OPC_W-1:0]     opcode,
  output logic [WORD_W-1:0]    addr_q,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 start
);
  logic              wr_ok;
  logic [DATA_W-1:0] rd_q;

  assign wr_ok = reg_we && !busy;
  assign start = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[BIT_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      opcode <= '0;
      addr_q <= '0;
    end else if (wr_ok) begin
      if (reg_addr == OFS_CTRL) begin
        cfg    <= cmd_unpack(reg_wdata);
        opcode <= reg_wdata[31:24];
      end
      if (reg_addr == OFS_ADDR) addr_q <= reg_wdata;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [REG_AW-1:0] WOFS = OFS_WR_LO + REG_AW'(4 * w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_data[w*WORD_W +: WORD_W] <= '0;
      else if (wr_ok && reg_addr == WOFS) wr_data[w*WORD_W +: WORD_W] <= reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q[w*WORD_W +: WORD_W] <= '0;
      else if (finish && cfg.rd_en) rd_q[w*WORD_W +: WORD_W] <= rd_capture[w*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) reg_rdata = cmd_pack(cfg, opcode, busy);
    if (reg_addr == OFS_ADDR) reg_rdata = addr_q;
    for (int w = 0; w < NWORDS; w++) begin
      if (reg_addr == OFS_RD_LO + REG_AW'(4 * w)) reg_rdata = rd_q[w*WORD_W +: WORD_W];
      if (reg_addr == OFS_WR_LO + REG_AW'(4 * w)) reg_rdata = wr_data[w*WORD_W +: WORD_W];
    end
  end

  // R11: nothing software-visible moves on a write during a command
  p_hold_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(cfg) && $stable(opcode) && $stable(addr_q) && $stable(wr_data)));

  // R12: read-back words ignore writes
  p_rd_readonly_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && (reg_addr == OFS_RD_LO || reg_addr == OFS_RD_LO + REG_AW'(4))) |=> $stable(rd_q));
endmodule

// File: rtl/fce_seq.sv
`timescale 1ns/1ps
module fce_seq
  import fce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_stb,
  input  cmd_t             cfg,
  output phase_e           ph,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             finish,
  output logic             busy,
  output logic             cs_n
);
  phase_e           ph_q, nxt;
  logic [CNT_W-1:0] cnt_q, len;
  logic             last;

  assign len    = phase_len(ph_q, cfg);
  assign last   = (cnt_q == len - CNT_W'(1));
  assign nxt    = phase_after(ph_q, cfg);
  assign busy   = (ph_q != PH_IDLE);
  assign cs_n   = !busy;
  assign adv    = bit_stb && busy;
  assign finish = adv && last && (nxt == PH_IDLE);
  assign ph     = ph_q;
  assign cnt    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      ph_q  <= PH_OPC;
      cnt_q <= '0;
    end else if (adv) begin
      if (last) begin
        ph_q  <= nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_start_opc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph_q == PH_OPC && cnt_q == '0));

  p_hold_no_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_stb) |=> ($stable(ph_q) && $stable(cnt_q)));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < len));

  p_phase_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ph_q == PH_IDLE || ph_q >= $past(ph_q)));

  p_finish_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/fce_shift.sv
`timescale 1ns/1ps
module fce_shift
  import fce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  phase_e            ph,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [1:0]        addr_cnt,
  input  logic [WORD_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rd_capture
);
  logic [POS_W-1:0]  dpos;
  logic [DATA_W-1:0] acc;
  logic              take;

  assign dpos = data_pos(cnt);
  assign take = adv && (ph == PH_RD);

  always_comb begin
    case (ph)
      PH_OPC:  sdo = opcode[3'd7 - cnt[2:0]];
      PH_ADDR: sdo = addr_q[addr_pos(addr_cnt, cnt)];
      PH_WR:   sdo = wr_data[dpos];
      default: sdo = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (start) acc <= '0;
    else if (take)  acc[dpos] <= sdi;
  end

  // final bit merged so the commit edge sees the whole word
  always_comb begin
    rd_capture = acc;
    if (take) rd_capture[dpos] = sdi;
  end

  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE && !adv) |=> $stable(sdo));
endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
  import fce_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 bit_stb,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 cs_n
);
  cmd_t              cfg;
  logic [OPC_W-1:0]  opcode;
  logic [WORD_W-1:0] addr_q;
  logic [DATA_W-1:0] wr_data, rd_capture;
  logic              start, busy, finish, adv;
  phase_e            ph;
  logic [CNT_W-1:0]  cnt;

  fce_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .finish(finish),
    .rd_capture(rd_capture), .cfg(cfg), .opcode(opcode), .addr_q(addr_q),
    .wr_data(wr_data), .start(start)
  );

  fce_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_stb(bit_stb), .cfg(cfg),
    .ph(ph), .cnt(cnt), .adv(adv), .finish(finish), .busy(busy), .cs_n(cs_n)
  );

  fce_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .ph(ph), .cnt(cnt),
    .opcode(opcode), .addr_cnt(cfg.addr_cnt), .addr_q(addr_q), .wr_data(wr_data),
    .sdi(sdi), .sdo(sdo), .rd_capture(rd_capture)
  );

  // R10: select low exactly while a phase is active, across phase changes
  p_cs_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !finish) |=> !cs_n);
endmodule

// File: tb/tb_flash_cmd_engine.sv
`timescale 1ns/1ps
module tb_flash_cmd_engine;
  localparam logic [7:0] A_CTRL = 8'h90, A_ADDR = 8'h94, A_RLO = 8'hA0, A_RHI = 8'hA4,
                         A_WLO = 8'hA8, A_WHI = 8'hAC;
  localparam logic [31:0] CTRL_MASK = 32'hFFFB_FF80;

  logic clk = 0, rst_n = 0, reg_we = 0, bit_stb = 0, sdi = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic sdo, cs_n;

  flash_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo), .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  // behavioural model
  bit          m_busy = 0;
  logic [31:0] m_ctrl = 0, m_addr = 0, m_wlo = 0, m_whi = 0, m_rlo = 0, m_rhi = 0;
  logic [63:0] m_acc = 0;
  bit          exp_q[$];
  int          kind_q[$];   // -1: driven bit, else receive position
  int checks = 0, errors = 0;
  int period = 1, cyc = 0;
  bit stb_on = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input bit b, input int k);
    exp_q.push_back(b);
    kind_q.push_back(k);
  endtask

  task automatic build(input logic [31:0] w);
    exp_q.delete();
    kind_q.delete();
    for (int i = 7; i >= 0; i--) push(w[24+i], -1);
    if (w[19]) begin
      int n = 8 * (int'(w[17:16]) + 1);
      for (int i = n - 1; i >= 0; i--) push(m_addr[i], -1);
    end
    for (int i = 0; i < int'(w[11:7]); i++) push(1'b0, -1);
    if (w[15]) begin
      for (int k = 0; k <= int'(w[14:12]); k++)
        for (int b = 7; b >= 0; b--)
          push(k < 4 ? m_wlo[8*k+b] : m_whi[8*(k-4)+b], -1);
    end
    if (w[23]) begin
      for (int k = 0; k <= int'(w[22:20]); k++)
        for (int b = 7; b >= 0; b--) push(1'b0, 8*k+b);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ctrl = 0; m_addr = 0; m_wlo = 0; m_whi = 0; m_rlo = 0; m_rhi = 0; m_acc = 0;
    end else begin
      bit pre;
      pre = m_busy;
      if (pre && bit_stb) begin
        int k;
        bit e;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        if (k >= 0) m_acc[k] = sdi;
        if (exp_q.size() == 0) begin
          m_busy = 0;
          if (m_ctrl[23]) begin m_rlo = m_acc[31:0]; m_rhi = m_acc[63:32]; end
        end
      end
      if (!pre && reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            m_ctrl = reg_wdata & CTRL_MASK;
            if (reg_wdata[0]) begin m_acc = 0; build(reg_wdata); m_busy = 1; end
          end
          A_ADDR: m_addr = reg_wdata;
          A_WLO:  m_wlo = reg_wdata;
          A_WHI:  m_whi = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // compare serial side on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cs_n === !m_busy, "R10", "chip select", {31'b0, cs_n}, {31'b0, !m_busy});
      if (m_busy) begin
        bit e;
        e = (kind_q[0] < 0) ? exp_q[0] : 1'b0;
        chk(sdo === e, "R4/R5/R6/R7/R8/R9", "serial out", {31'b0, sdo}, {31'b0, e});
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    bit_stb = stb_on && (cyc % period == 0);
    sdi = 1'($urandom);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata === e, tag, "register read", reg_rdata, e);
  endtask

  task automatic check_regs(input string tag);
    rd_chk(A_CTRL, m_ctrl | {30'b0, m_busy, 1'b0}, tag);
    rd_chk(A_ADDR, m_addr, tag);
    rd_chk(A_WLO, m_wlo, tag);
    rd_chk(A_WHI, m_whi, tag);
    rd_chk(A_RLO, m_rlo, tag);
    rd_chk(A_RHI, m_rhi, tag);
  endtask

  // counts: 0 disables the phase, otherwise number of bytes
  function automatic logic [31:0] cw(input logic [7:0] op, input int rdn, input int an,
                                     input int wn, input int dum);
    logic [31:0] w;
    w = 0;
    w[31:24] = op;
    if (rdn > 0) begin w[23] = 1; w[22:20] = 3'(rdn - 1); end
    if (an > 0)  begin w[19] = 1; w[17:16] = 2'(an - 1); end
    if (wn > 0)  begin w[15] = 1; w[14:12] = 3'(wn - 1); end
    w[11:7] = 5'(dum);
    return w;
  endfunction

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [31:0] w, input int per, input string tag);
    period = per;
    wr(A_CTRL, w | 32'd1);
    rd_chk(A_CTRL, (w & CTRL_MASK) | 32'd2, "R3");
    wait_idle();
    check_regs(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_regs("R1");
    stb_on = 1;
    // R2 register map
    wr(A_ADDR, 32'hC1A2B3D4);
    wr(A_WLO, 32'h44332211);
    wr(A_WHI, 32'h88776655);
    wr(A_CTRL, cw(8'h5A, 3, 2, 5, 9) | 32'h0004_007E);
    check_regs("R2");
    rd_chk(8'h00, 32'h0, "R2");
    rd_chk(8'h98, 32'h0, "R2");
    // R12 read-back words are read-only
    wr(A_RLO, 32'hDEADBEEF);
    wr(A_RHI, 32'hCAFEF00D);
    check_regs("R12");
    // R5 opcode only
    run_cmd(cw(8'h06, 0, 0, 0, 0), 1, "R5");
    // R9 three-byte read, slow strobe
    run_cmd(cw(8'h9F, 3, 0, 0, 0), 3, "R9");
    // R6/R8 three address bytes then two data bytes, no dummy (R7 skip)
    run_cmd(cw(8'h02, 0, 3, 2, 0), 2, "R6");
    // R6/R7/R9 four address bytes, eight dummy cycles, eight read bytes
    run_cmd(cw(8'hEB, 8, 4, 0, 8), 1, "R7");
    // R8 one address byte, one dummy, eight write bytes, one read byte
    wr(A_ADDR, 32'h0000_00A5);
    run_cmd(cw(8'h12, 1, 1, 8, 1), 4, "R8");
    // R9 read-back untouched without a read phase
    run_cmd(cw(8'h04, 0, 0, 1, 0), 1, "R9");
    // R4 strobe paused mid command
    period = 1;
    wr(A_CTRL, cw(8'h3B, 2, 2, 0, 3) | 32'd1);
    stb_on = 0;
    repeat (12) @(negedge clk);
    rd_chk(A_CTRL, (cw(8'h3B, 2, 2, 0, 3) & CTRL_MASK) | 32'd2, "R4");
    stb_on = 1;
    wait_idle();
    check_regs("R4");
    // R11 writes during a command are ignored
    period = 5;
    wr(A_CTRL, cw(8'h05, 1, 0, 0, 0) | 32'd1);
    wr(A_CTRL, cw(8'hAA, 2, 1, 0, 0) | 32'd1);
    wr(A_ADDR, 32'h12345678);
    wr(A_WLO, 32'h0BADF00D);
    wr(A_WHI, 32'h0BADF00D);
    rd_chk(A_CTRL, (cw(8'h05, 1, 0, 0, 0) & CTRL_MASK) | 32'd2, "R11");
    wait_idle();
    check_regs("R11");
    // R10 back-to-back command after completion
    run_cmd(cw(8'hC7, 0, 0, 0, 31), 1, "R10");
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule